// File: doc/BRIEF.md
# Pre-Trigger Signal History Capture

This block records a short sample history of a group of trigger-related input lines, so that the conditions on those lines just before a trigger can be attached to the event record. Each monitored line has its own 32-bit history register. While the block is armed, every register moves one place on each clock and takes in the newest sample of its line. Each word is therefore the recent time history of one line.

The first accepted trigger freezes all registers on the same edge. A simple address-based read port then returns any history word, or a status word, one clock after the address is presented. A re-arm pulse restarts sampling and leaves the frozen contents in place until new samples shift them out. Inputs are expected to be synchronous to the block clock already. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pretrig_history`

## Requirements
- R1: Two rising edges after `rst_n` is released, every history word reads as zero and `frozen_o` is 0.
- R2: While armed, on every rising edge each history word for line k shifts left by one and takes `lines_i[k]` into bit 0. Address k (0..8) reads the word for line k.
- R3: While frozen, no history word changes, whatever the line inputs do.
- R4: A `trig_i` high at a rising edge while armed freezes all words at that same edge. Bit 0 of each frozen word is the sample taken at that edge. This holds even when `rearm_i` is high in the same cycle.
- R5: While frozen, further `trig_i` pulses have no effect on the state or on the stored words.
- R6: A `rearm_i` high at a rising edge while frozen returns the block to armed at that edge. The words are not cleared, and shifting resumes on the following edge. `rearm_i` while armed has no effect.
- R7: `rd_data_o` returns the word selected by `rd_addr_i` one rising edge later. Address 9 returns a status word whose bit 0 is the frozen flag and whose other bits are zero. Addresses 10 to 15 return zero.
- R8: `frozen_o` is 1 exactly while the block is frozen and holds valid captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | 9 | Monitored lines, one bit per history word |
| trig_i | input | 1 | Accepted trigger pulse |
| rearm_i | input | 1 | Restart sampling after a capture |
| rd_addr_i | input | 4 | Read address (0..8 words, 9 status) |
| rd_data_o | output | 32 | Registered read data |
| frozen_o | output | 1 | Capture frozen and valid |

## Verification
A history word moves at the same rising edge that samples its line. `frozen_o` changes at the edge that sees `trig_i` or `rearm_i`. Read data appears one edge after the address is driven. The bench therefore drives every input just after a falling edge and lets exactly one rising edge pass. At that rising edge it updates its own model: the read result is predicted from the state before the edge, and the flag from the state after it. It then compares both outputs at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/pth_pkg.sv
package pth_pkg;
  typedef enum logic {
    CAP_ARMED  = 1'b0,
    CAP_FROZEN = 1'b1
  } cap_state_e;

  localparam int STATUS_FROZEN_BIT = 0;
endpackage

// File: rtl/pth_rst_sync.sv
module pth_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/pth_ctrl.sv
module pth_ctrl
  import pth_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic rearm_i,
  output logic shift_en_o,
  output logic frozen_o
);
  cap_state_e state_q;
  cap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CAP_ARMED:  if (trig_i)  state_d = CAP_FROZEN;
      CAP_FROZEN: if (rearm_i) state_d = CAP_ARMED;
      default:    state_d = CAP_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CAP_ARMED;
    else        state_q <= state_d;
  end

  assign shift_en_o = (state_q == CAP_ARMED);
  assign frozen_o   = (state_q == CAP_FROZEN);

  assert_freeze_on_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_o && trig_i) |=> frozen_o);
  assert_trig_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o && !rearm_i) |=> frozen_o);
  assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o && rearm_i) |=> !frozen_o);
  assert_armed_no_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_o && !trig_i) |=> !frozen_o);
endmodule

// File: rtl/pth_lane.sv
module pth_lane #(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             sample_i,
  output logic [DEPTH-1:0] word_o
);
  logic [DEPTH-1:0] word_q;
  logic [DEPTH-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en_i) word_d = {word_q[DEPTH-2:0], sample_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  assert_newest_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (word_o[0] == $past(sample_i)));
endmodule

// File: rtl/pth_readmux.sv
module pth_readmux
  import pth_pkg::*;
#(
  parameter int NUM_LINES = 9,
  parameter int DEPTH     = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES*DEPTH-1:0] bank_i,
  input  logic                       frozen_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [DEPTH-1:0]           data_o
);
  logic [DEPTH-1:0] data_q;
  logic [DEPTH-1:0] data_d;
  logic [DEPTH-1:0] status_w;

  always_comb begin
    status_w = '0;
    status_w[STATUS_FROZEN_BIT] = frozen_i;
  end

  always_comb begin
    data_d = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (int'(addr_i) == k) data_d = bank_i[k*DEPTH +: DEPTH];
    end
    if (int'(addr_i) == NUM_LINES) data_d = status_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;

  assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_i) > NUM_LINES) |=> (data_o == '0));
  assert_status_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr_i) == NUM_LINES) |=> (data_o[STATUS_FROZEN_BIT] == $past(frozen_i)));
endmodule

// File: rtl/pretrig_history.sv
module pretrig_history #(
  parameter  int NUM_LINES = 9,
  parameter  int DEPTH     = 32,
  localparam int ADDR_W    = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 trig_i,
  input  logic                 rearm_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DEPTH-1:0]     rd_data_o,
  output logic                 frozen_o
);
  logic                       rst_sync_n;
  logic                       shift_en;
  logic                       frozen;
  logic [NUM_LINES*DEPTH-1:0] bank;

  pth_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pth_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig_i     (trig_i),
    .rearm_i    (rearm_i),
    .shift_en_o (shift_en),
    .frozen_o   (frozen)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    pth_lane #(.DEPTH(DEPTH)) i_lane (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .shift_en_i (shift_en),
      .sample_i   (lines_i[g]),
      .word_o     (bank[g*DEPTH +: DEPTH])
    );
  end

  pth_readmux #(
    .NUM_LINES (NUM_LINES),
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W)
  ) i_readmux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bank_i   (bank),
    .frozen_i (frozen),
    .addr_i   (rd_addr_i),
    .data_o   (rd_data_o)
  );

  assign frozen_o = frozen;

  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frozen_o |=> $stable(bank));
  assert_capture_needs_trig_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(frozen_o) |-> $past(trig_i));
endmodule

// File: tb/test_pretrig_history.sv
`timescale 1ns/100ps
module test_pretrig_history;
  localparam int NL = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] lines;
  logic          trig;
  logic          rearm;
  logic [3:0]    addr;
  logic [DW-1:0] rd_data;
  logic          frozen;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] m_word [NL];
  logic          m_frozen;

  always #2.5 clk = ~clk;

  pretrig_history i_pretrig_history (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_i   (lines),
    .trig_i    (trig),
    .rearm_i   (rearm),
    .rd_addr_i (addr),
    .rd_data_o (rd_data),
    .frozen_o  (frozen)
  );

  function automatic logic [DW-1:0] model_read(input logic [3:0] a);
    if (int'(a) < NL)  return m_word[a];
    if (int'(a) == NL) return {{(DW-1){1'b0}}, m_frozen};
    return '0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic [NL-1:0] ln, input logic tg, input logic ra,
                      input logic [3:0] ad);
    logic [DW-1:0] exp_rd;
    string tag;
    lines = ln; trig = tg; rearm = ra; addr = ad;
    exp_rd = model_read(ad);
    if (int'(ad) < NL) tag = m_frozen ? "R3" : "R2";
    else               tag = "R7";
    @(posedge clk);
    if (!m_frozen) begin
      for (int k = 0; k < NL; k++) m_word[k] = {m_word[k][DW-2:0], ln[k]};
      if (tg) m_frozen = 1'b1;
    end else if (ra) begin
      m_frozen = 1'b0;
    end
    @(negedge clk);
    check(rd_data == exp_rd, tag, rd_data, exp_rd);
    check(frozen == m_frozen, "R8", {31'b0, frozen}, {31'b0, m_frozen});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NL-1:0] tsample;
    logic [DW-1:0] snap [NL];
    void'($urandom(32'd20240917));
    rst_n = 1'b0; lines = '0; trig = 1'b0; rearm = 1'b0; addr = '0;
    m_frozen = 1'b0;
    for (int k = 0; k < NL; k++) m_word[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, read every address with idle inputs
    check(frozen == 1'b0, "R1", {31'b0, frozen}, '0);
    for (int a = 0; a < 12; a++) begin
      addr = 4'(a);
      @(negedge clk);
      check(rd_data == '0, "R1", rd_data, '0);
    end

    // R2: fill with a walking pattern
    for (int c = 0; c < 40; c++) step(NL'(c * 37 + 5), 1'b0, 1'b0, 4'(c % 10));

    // R4: trigger with rearm asserted too, bit 0 must hold this sample
    tsample = 9'b101100111;
    step(tsample, 1'b1, 1'b1, 4'd9);
    check(frozen == 1'b1, "R4", {31'b0, frozen}, 32'd1);
    for (int k = 0; k < NL; k++) snap[k] = m_word[k];
    for (int k = 0; k < NL; k++) begin
      step(~tsample, 1'b0, 1'b0, 4'(k));
      check(rd_data[0] == tsample[k], "R4", {31'b0, rd_data[0]}, {31'b0, tsample[k]});
    end

    // R5: repeated triggers while frozen change nothing
    for (int c = 0; c < 6; c++) step(NL'($urandom), 1'b1, 1'b0, 4'(c));
    for (int k = 0; k < NL; k++) begin
      step('0, 1'b1, 1'b0, 4'(k));
      check(rd_data == snap[k], "R5", rd_data, snap[k]);
    end

    // R6: rearm keeps contents, shifting restarts one edge later
    step('1, 1'b0, 1'b1, 4'd0);
    check(frozen == 1'b0, "R6", {31'b0, frozen}, '0);
    check(rd_data == snap[0], "R6", rd_data, snap[0]);
    step('1, 1'b0, 1'b0, 4'd0);
    check(rd_data == snap[0], "R6", rd_data, snap[0]);
    step('0, 1'b0, 1'b0, 4'd0);
    check(rd_data == {snap[0][DW-2:0], 1'b1}, "R6", rd_data, {snap[0][DW-2:0], 1'b1});
    // R6: rearm while armed has no effect
    step('1, 1'b0, 1'b1, 4'd9);
    check(frozen == 1'b0, "R6", {31'b0, frozen}, '0);

    // R7: out-of-range addresses
    for (int a = 10; a < 16; a++) step(NL'($urandom), 1'b0, 1'b0, 4'(a));

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      step(NL'($urandom), ($urandom % 20) == 0, ($urandom % 8) == 0, 4'($urandom % 12));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule